// File: doc/BRIEF.md
# Indirect CSR Access Permission Gate

This block decides, for one CSR access at a time, whether an access to the supervisor or virtual-supervisor indirect-register window may proceed. It looks at the CSR address, the current privilege mode and virtualization state, and two access-enable bits. The first enable bit comes from the machine-level state-enable register and the second from the hypervisor-level one. The result is one of four verdicts: allow, raise an illegal-instruction exception, raise a virtual-instruction exception, or redirect the access to the virtual-supervisor copy. The block holds no select register and no backing state. The CSR datapath supplies two flags: whether the current select value is implemented at hypervisor-supervisor level, and whether it is implemented at virtual-supervisor level.

Each window has eight slots. The slot at offset 0 is the select register, offsets 1 to 3 and 5 to 7 are the alias registers, and offset 4 is not part of the window. The decision is a fixed priority chain. Machine mode is never blocked by the enable bits. Below machine mode, the machine enable is checked first and the hypervisor enable second. The rules for the virtual modes come next, and the select-implemented check comes last. The verdict is registered, so it appears one clock after the request.

Top module: `csr_ind_gate`

## Requirements
- R1: An address hits when it is 0x150-0x153 or 0x155-0x157 (supervisor window) or 0x250-0x253 or 0x255-0x257 (virtual-supervisor window). Offset 0 of a window is the select register. Any other address, including 0x154 and 0x254, gives rsp_hit=0 and verdict 0. Verdict codes are 0 allow, 1 illegal-instruction, 2 virtual-instruction and 3 redirect. Mode codes are 0 M, 1 HS, 2 U, 3 VS and 4 VU; codes 5 to 7 are reserved.
- R2: rsp_valid, rsp_hit and rsp_verdict are the registered response to the request of the previous cycle. A synchronous reset sets rsp_valid and rsp_hit to 0 and rsp_verdict to 0.
- R3: In M mode the enable bits have no effect. A select slot gives allow. An alias slot gives allow when sel_impl_hs=1 and illegal-instruction when it is 0.
- R4: In any mode other than M, when men=0, a hit gives illegal-instruction.
- R5: In U mode, and in any reserved mode code, a hit gives illegal-instruction.
- R6: In VS or VU mode with men=1, a hit in the virtual-supervisor window gives virtual-instruction.
- R7: In VS or VU mode with men=1 and hen=0, a hit in the supervisor window gives virtual-instruction, whatever the select flags are.
- R8: In VU mode with men=1, a hit in the supervisor window gives virtual-instruction.
- R9: In VS mode with men=1 and hen=1, the supervisor select slot gives redirect. A supervisor alias slot gives redirect when both select flags are 1.
- R10: In VS mode with men=1 and hen=1, a supervisor alias slot gives illegal-instruction when sel_impl_hs=0. It gives virtual-instruction when sel_impl_hs=1 and sel_impl_vs=0.
- R11: In HS mode with men=1, both windows follow the M-mode rule of R3, and virtual-instruction never results.
- R12: With HAS_HYP=0, a virtual-supervisor window hit gives illegal-instruction in every mode, and mode codes 3 and 4 also give illegal-instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | ADDR_W | CSR address of the access |
| req_mode | input | 3 | Current mode code (R1) |
| men | input | 1 | Machine-level access-enable bit for the indirect window |
| hen | input | 1 | Hypervisor-level access-enable bit for the indirect window |
| sel_impl_hs | input | 1 | Current select value is implemented at HS level |
| sel_impl_vs | input | 1 | Current select value is implemented at VS level |
| rsp_valid | output | 1 | Response valid, one cycle after req_valid |
| rsp_hit | output | 1 | Address was inside an indirect window |
| rsp_verdict | output | 2 | Verdict code (R1) |

## Verification
The hardest verdict to reach is the split in VS mode between illegal-instruction and virtual-instruction for a supervisor alias slot. It needs men=1, hen=1, an alias offset rather than the select slot or the hole at offset 4, and a particular pair of select flags, all in the same request. Random stimulus rarely lines these up. Directed vectors therefore step through every combination of the two flags at an alias slot in VS mode. The random phase then biases addresses into the two windows and biases the enable bits toward 1, so the deep end of the priority chain is reached often. A second instance built without the hypervisor option runs on the same stimulus, to cover the R12 rules.

// File: rtl/csr_ind_pkg.sv
package csr_ind_pkg;
  typedef enum logic [1:0] {
    VD_ALLOW    = 2'd0,
    VD_ILLEGAL  = 2'd1,
    VD_VIRTUAL  = 2'd2,
    VD_REDIRECT = 2'd3
  } verdict_e;

  typedef enum logic [2:0] {
    MD_M  = 3'd0,
    MD_HS = 3'd1,
    MD_U  = 3'd2,
    MD_VS = 3'd3,
    MD_VU = 3'd4
  } mode_e;

  typedef struct packed {
    logic hit;
    logic sup;
    logic vsup;
    logic is_sel;
  } addr_class_t;
endpackage

// File: rtl/csr_ind_decode.sv
module csr_ind_decode
  import csr_ind_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int WIN       = 8,
  parameter int HOLE_OFS  = 4,
  parameter logic [ADDR_W-1:0] SUP_BASE  = 12'h150,
  parameter logic [ADDR_W-1:0] VSUP_BASE = 12'h250
) (
  input  logic [ADDR_W-1:0] addr,
  output addr_class_t       cls
);
  localparam int OFS_W  = $clog2(WIN);
  localparam int NBANK  = 2;

  logic [NBANK-1:0] bank_hit;
  logic [OFS_W-1:0] ofs;

  assign ofs = addr[OFS_W-1:0];

  genvar b;
  generate
    for (b = 0; b < NBANK; b++) begin : g_bank
      localparam logic [ADDR_W-1:0] BASE = (b == 0) ? SUP_BASE : VSUP_BASE;
      assign bank_hit[b] = (addr[ADDR_W-1:OFS_W] == BASE[ADDR_W-1:OFS_W]) &&
                           (ofs != OFS_W'(HOLE_OFS));
    end
  endgenerate

  always_comb begin
    cls.sup    = bank_hit[0];
    cls.vsup   = bank_hit[1];
    cls.hit    = |bank_hit;
    cls.is_sel = (ofs == '0);
  end
endmodule

// File: rtl/csr_ind_rules.sv
module csr_ind_rules
  import csr_ind_pkg::*;
#(
  parameter bit HAS_HYP = 1'b1
) (
  input  addr_class_t cls,
  input  logic [2:0]  mode,
  input  logic        men,
  input  logic        hen,
  input  logic        impl_hs,
  input  logic        impl_vs,
  output verdict_e    verdict
);
  logic is_virt, is_rsvd, plain_ok;

  assign is_virt  = (mode == MD_VS) || (mode == MD_VU);
  assign is_rsvd  = (mode > MD_VU) || (is_virt && !HAS_HYP);
  assign plain_ok = cls.is_sel || impl_hs;

  always_comb begin
    verdict = VD_ALLOW;
    if (!cls.hit)                       verdict = VD_ALLOW;
    else if (cls.vsup && !HAS_HYP)      verdict = VD_ILLEGAL;
    else if (is_rsvd)                   verdict = VD_ILLEGAL;
    else if (mode == MD_M)              verdict = plain_ok ? VD_ALLOW : VD_ILLEGAL;
    else if (!men)                      verdict = VD_ILLEGAL;
    else if (mode == MD_U)              verdict = VD_ILLEGAL;
    else if (mode == MD_HS)             verdict = plain_ok ? VD_ALLOW : VD_ILLEGAL;
    else if (cls.sup && !hen)           verdict = VD_VIRTUAL;
    else if (cls.vsup)                  verdict = VD_VIRTUAL;
    else if (mode == MD_VU)             verdict = VD_VIRTUAL;
    else if (cls.is_sel)                verdict = VD_REDIRECT;
    else if (!impl_hs)                  verdict = VD_ILLEGAL;
    else if (!impl_vs)                  verdict = VD_VIRTUAL;
    else                                verdict = VD_REDIRECT;
  end
endmodule

// File: rtl/csr_ind_gate.sv
module csr_ind_gate
  import csr_ind_pkg::*;
#(
  parameter int ADDR_W  = 12,
  parameter bit HAS_HYP = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [2:0]        req_mode,
  input  logic              men,
  input  logic              hen,
  input  logic              sel_impl_hs,
  input  logic              sel_impl_vs,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [1:0]        rsp_verdict
);
  addr_class_t cls;
  verdict_e    verdict;

  csr_ind_decode #(.ADDR_W(ADDR_W)) u_decode (
    .addr (req_addr),
    .cls  (cls)
  );

  csr_ind_rules #(.HAS_HYP(HAS_HYP)) u_rules (
    .cls     (cls),
    .mode    (req_mode),
    .men     (men),
    .hen     (hen),
    .impl_hs (sel_impl_hs),
    .impl_vs (sel_impl_vs),
    .verdict (verdict)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid   <= 1'b0;
      rsp_hit     <= 1'b0;
      rsp_verdict <= VD_ALLOW;
    end else begin
      rsp_valid   <= req_valid;
      rsp_hit     <= cls.hit;
      rsp_verdict <= verdict;
    end
  end
endmodule

// File: rtl/csr_ind_gate_chk.sv
module csr_ind_gate_chk #(
  parameter int ADDR_W  = 12,
  parameter bit HAS_HYP = 1'b1
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic [ADDR_W-1:0] req_addr,
  input logic [2:0]        req_mode,
  input logic              men,
  input logic              hen,
  input logic              sel_impl_hs,
  input logic              sel_impl_vs,
  input logic              rsp_valid,
  input logic              rsp_hit,
  input logic [1:0]        rsp_verdict
);
  logic in_s, in_v, any_hit, virt_mode;
  assign in_s = (req_addr >= ADDR_W'(12'h150)) && (req_addr <= ADDR_W'(12'h157)) &&
                (req_addr != ADDR_W'(12'h154));
  assign in_v = (req_addr >= ADDR_W'(12'h250)) && (req_addr <= ADDR_W'(12'h257)) &&
                (req_addr != ADDR_W'(12'h254));
  assign any_hit   = in_s || in_v;
  assign virt_mode = (req_mode == 3'd3) || (req_mode == 3'd4);

  AST_MISS_ALLOW: assert property (@(posedge clk) disable iff (rst)
    !any_hit |=> (!rsp_hit && rsp_verdict == 2'd0)); // R1
  AST_VALID_FOLLOW: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid); // R2
  AST_MEN_BLOCK: assert property (@(posedge clk) disable iff (rst)
    (any_hit && req_mode != 3'd0 && !men) |=> rsp_verdict == 2'd1); // R4
  AST_U_ILLEGAL: assert property (@(posedge clk) disable iff (rst)
    (any_hit && req_mode == 3'd2) |=> rsp_verdict == 2'd1); // R5
  AST_VWIN_VIRT: assert property (@(posedge clk) disable iff (rst)
    (HAS_HYP && in_v && virt_mode && men) |=> rsp_verdict == 2'd2); // R6
  AST_HEN_BLOCK: assert property (@(posedge clk) disable iff (rst)
    (HAS_HYP && in_s && virt_mode && men && !hen) |=> rsp_verdict == 2'd2); // R7
  AST_VU_VIRT: assert property (@(posedge clk) disable iff (rst)
    (HAS_HYP && in_s && req_mode == 3'd4 && men) |=> rsp_verdict == 2'd2); // R8
  AST_REDIRECT_VS_ONLY: assert property (@(posedge clk) disable iff (rst)
    (rsp_verdict == 2'd3) |-> ($past(req_mode) == 3'd3)); // R9
  AST_HS_NO_VIRT: assert property (@(posedge clk) disable iff (rst)
    (req_mode == 3'd1) |=> rsp_verdict != 2'd2); // R11
  AST_NOHYP_VWIN: assert property (@(posedge clk) disable iff (rst)
    (!HAS_HYP && in_v) |=> rsp_verdict == 2'd1); // R12

  logic unused_ok;
  assign unused_ok = sel_impl_hs ^ sel_impl_vs;
endmodule

bind csr_ind_gate csr_ind_gate_chk #(.ADDR_W(ADDR_W), .HAS_HYP(HAS_HYP)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
  .req_mode(req_mode), .men(men), .hen(hen), .sel_impl_hs(sel_impl_hs),
  .sel_impl_vs(sel_impl_vs), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
  .rsp_verdict(rsp_verdict)
);

// File: tb/csr_ind_gate_bench.sv
`timescale 1ns/1ps
module csr_ind_gate_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [11:0] req_addr = '0;
  logic [2:0]  req_mode = '0;
  logic        men = 1'b0, hen = 1'b0, ihs = 1'b0, ivs = 1'b0;
  logic        rv_a, rh_a, rv_b, rh_b;
  logic [1:0]  vd_a, vd_b;
  int          n_chk = 0, n_bad = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  csr_ind_gate #(.HAS_HYP(1'b1)) u_csr_ind_gate (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .req_mode(req_mode), .men(men), .hen(hen), .sel_impl_hs(ihs),
    .sel_impl_vs(ivs), .rsp_valid(rv_a), .rsp_hit(rh_a), .rsp_verdict(vd_a));

  csr_ind_gate #(.HAS_HYP(1'b0)) u_csr_ind_gate_nohyp (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .req_mode(req_mode), .men(men), .hen(hen), .sel_impl_hs(ihs),
    .sel_impl_vs(ivs), .rsp_valid(rv_b), .rsp_hit(rh_b), .rsp_verdict(vd_b));

  // Reference model built from the requirement text.
  function automatic void ref_model(input logic [11:0] a, input logic [2:0] m,
      input logic me, input logic he, input logic hs, input logic vs, input bit hyp,
      output logic hit, output logic [1:0] vd, output string tag);
    logic s, v, sel, virt;
    s   = (a[11:3] == 9'h02A) && (a[2:0] != 3'd4);
    v   = (a[11:3] == 9'h04A) && (a[2:0] != 3'd4);
    sel = (a[2:0] == 3'd0);
    virt = (m == 3'd3) || (m == 3'd4);
    hit = s || v;
    if (!hit)                        begin vd = 2'd0; tag = "R1"; end
    else if (!hyp && (v || virt))    begin vd = 2'd1; tag = "R12"; end
    else if (m > 3'd4)               begin vd = 2'd1; tag = "R5"; end
    else if (m == 3'd0)              begin vd = (sel || hs) ? 2'd0 : 2'd1; tag = "R3"; end
    else if (!me)                    begin vd = 2'd1; tag = "R4"; end
    else if (m == 3'd2)              begin vd = 2'd1; tag = "R5"; end
    else if (m == 3'd1)              begin vd = (sel || hs) ? 2'd0 : 2'd1; tag = "R11"; end
    else if (v)                      begin vd = 2'd2; tag = "R6"; end
    else if (!he)                    begin vd = 2'd2; tag = "R7"; end
    else if (m == 3'd4)              begin vd = 2'd2; tag = "R8"; end
    else if (sel)                    begin vd = 2'd3; tag = "R9"; end
    else if (!hs)                    begin vd = 2'd1; tag = "R10"; end
    else if (!vs)                    begin vd = 2'd2; tag = "R10"; end
    else                             begin vd = 2'd3; tag = "R9"; end
  endfunction

  task automatic cmp(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic apply(input logic [11:0] a, input logic [2:0] m, input logic me,
      input logic he, input logic hs, input logic vs);
    logic eh; logic [1:0] ev; string t;
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_mode = m;
    men = me; hen = he; ihs = hs; ivs = vs;
    @(posedge clk); #1;
    ref_model(a, m, me, he, hs, vs, 1'b1, eh, ev, t);
    cmp("R2", "rsp_valid", int'(rv_a), 1);
    cmp(t, "hit", int'(rh_a), int'(eh));
    cmp(t, "verdict", int'(vd_a), int'(ev));
    ref_model(a, m, me, he, hs, vs, 1'b0, eh, ev, t);
    cmp(t, "nohyp verdict", int'(vd_b), int'(ev));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #400000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [11:0] a;
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1;
    cmp("R2", "reset valid", int'(rv_a), 0);
    cmp("R2", "reset hit", int'(rh_a), 0);
    cmp("R2", "reset verdict", int'(vd_a), 0);
    @(negedge clk); rst = 1'b0;

    // Directed corners
    apply(12'h154, 3'd0, 1, 1, 1, 1);   // R1 hole
    apply(12'h254, 3'd3, 1, 1, 1, 1);   // R1 hole
    apply(12'h158, 3'd0, 1, 1, 1, 1);   // R1 just past window
    apply(12'h151, 3'd0, 0, 0, 0, 0);   // R3 alias not implemented
    apply(12'h150, 3'd0, 0, 0, 0, 0);   // R3 select
    apply(12'h257, 3'd0, 0, 0, 1, 0);   // R3
    apply(12'h152, 3'd1, 0, 1, 1, 1);   // R4
    apply(12'h150, 3'd2, 1, 1, 1, 1);   // R5
    apply(12'h151, 3'd6, 1, 1, 1, 1);   // R5 reserved
    apply(12'h250, 3'd3, 1, 1, 1, 1);   // R6
    apply(12'h255, 3'd4, 1, 0, 1, 1);   // R6
    apply(12'h153, 3'd3, 1, 0, 1, 1);   // R7
    apply(12'h150, 3'd4, 1, 1, 1, 1);   // R8
    apply(12'h150, 3'd3, 1, 1, 0, 0);   // R9 select
    for (int f = 0; f < 4; f++)          // R9 / R10 flag split
      apply(12'h156, 3'd3, 1, 1, f[1], f[0]);
    apply(12'h251, 3'd1, 1, 0, 0, 0);   // R11
    apply(12'h251, 3'd1, 1, 0, 1, 0);   // R11

    // Reset mid-run (R2)
    @(negedge clk); rst = 1'b1; req_valid = 1'b1;
    @(posedge clk); #1;
    cmp("R2", "reset mid valid", int'(rv_a), 0);
    @(negedge clk); rst = 1'b0; req_valid = 1'b0;
    @(posedge clk); #1;
    cmp("R2", "idle valid", int'(rv_a), 0);

    // Constrained random
    for (int i = 0; i < 3000; i++) begin
      case ($urandom_range(3))
        0: a = 12'h150 | 12'($urandom_range(7));
        1: a = 12'h250 | 12'($urandom_range(7));
        2: a = 12'($urandom_range(4095));
        default: a = (($urandom_range(1) != 0) ? 12'h140 : 12'h240) + 12'($urandom_range(31));
      endcase
      apply(a, 3'($urandom_range(7)), ($urandom_range(3) != 0),
            ($urandom_range(3) != 0), 1'($urandom_range(1)), 1'($urandom_range(1)));
    end
    finish_run();
  end
endmodule